// File: doc/BRIEF.md
# Corner-Programmed Display Timing Generator

This block produces raster timing from the pixel clock. A horizontal and a vertical counter sweep a frame whose size is set by the position of its last pixel. All geometry (frame, visible area, three overlay windows) is given as corner coordinates in that single counter space. From the counters the block derives sync pulses, a visible-area enable, one window flag per overlay channel, two context-load trigger pulses and four line-compare interrupt sources with latched status, write-one-to-clear and a mask.

Software programs the geometry through a word-addressed write/read port while the generator is stopped or running. Geometry writes are staged and only applied at a frame boundary, so a frame never mixes old and new timing. A start bit runs the generator; while it is clear the counters rest at zero and every timing output is quiet.

Top module: `disp_tgen_top`

## Requirements
- R1: Registers sit at word offsets: 0 control, 1 interrupt status (read), 2 interrupt clear (write), 3 interrupt mask, 4 frame last position, 5 visible top corner, 6 visible bottom corner, 7 sync sizes, 8 context-load triggers, 9 to 12 line-compare 0 to 3, 13+2c and 14+2c top and bottom corners of channel c+1 (c = 0..2). A coordinate word carries X in bits 12:0 and Y in bits 28:16; reading any coordinate register returns the last written X and Y with all other bits 0.
- R2: While running, X counts 0 up to the frame X field and wraps to 0; Y advances on each X wrap and wraps to 0 after the frame Y field. `pos_x`/`pos_y` show the counters.
- R3: `disp_en` is 1 exactly when running and top.X < X <= bottom.X and top.Y < Y <= bottom.Y for the visible corners.
- R4: `ch_act[c]` follows the same corner rule with channel c+1's corners, gated by its enable bit in the control word: bit 2 for channel 1, bit 1 for channel 2, bit 0 for channel 3. Control bit 8 is the start bit; control reads back bit 8 and bits 2:0.
- R5: A channel whose top and bottom corners are both zero is never active, even when enabled.
- R6: `hsync` is 1 when running and X is below the X field of the sync-size register; `vsync` is 1 when running and Y is below its Y field.
- R7: Line-compare source k sets status bit k in the cycle after the counter sits at X = 0 with Y equal to bits 28:16 of line register k; status bits stay set until cleared and read at offset 1, bits 3:0.
- R8: Writing 1 to bit k at offset 2 clears status bit k; a new event for that bit in the same cycle wins over the clear.
- R9: `irq` is 1 whenever any status bit is set whose mask bit (offset 3, bits 3:0) is 1.
- R10: `ctx_db_pulse` is 1 for the single cycle at X = 0 on the line whose Y equals bits 12:0 of the trigger register; `ctx_sb_pulse` likewise for bits 28:16.
- R11: From the cycle after a write that clears the start bit, and out of reset, the counters are zero on the next cycle and sync, enable, channel and trigger outputs are 0.
- R12: Geometry writes (offsets 4 to 18) made while running take effect for the frame that starts after the current frame ends; while stopped they take effect on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register word offset for write and read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| disp_en | output | 1 | Inside visible area |
| ch_act | output | 3 | Bit c: inside window of channel c+1 |
| pos_x | output | 13 | Horizontal counter |
| pos_y | output | 13 | Vertical counter |
| ctx_db_pulse | output | 1 | Double-buffered context-load trigger |
| ctx_sb_pulse | output | 1 | Single-buffered context-load trigger |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with its defaults: three channels, four line-compare sources, 13-bit coordinates and a 5-bit word offset. Because the frame size is itself a register, the bench programs frames of only 9 to 24 by 6 to 13 positions, which puts many frame wraps, every line-compare source, both trigger pulses and mid-frame geometry changes within a few hundred cycles each. Random geometry with stray upper bits and all-zero channel corners mixes with a fixed directed frame where a clear and a frame-size change land in the middle of a frame.

// File: rtl/disp_tgen_pkg.sv
package disp_tgen_pkg;

  localparam int unsigned CW        = 13;  // coordinate field width
  localparam int unsigned DW        = 32;  // register data width
  localparam int unsigned YLSB      = 16;  // lsb of Y field in a coordinate word
  localparam int unsigned START_BIT = 8;

  // word offsets
  localparam int unsigned A_CTRL = 0;
  localparam int unsigned A_STAT = 1;
  localparam int unsigned A_CLR  = 2;
  localparam int unsigned A_MASK = 3;
  localparam int unsigned A_GEO  = 4;

  // index inside the geometry bank (offset = A_GEO + index)
  localparam int unsigned G_EXT  = 0;
  localparam int unsigned G_DTOP = 1;
  localparam int unsigned G_DBOT = 2;
  localparam int unsigned G_SYNC = 3;
  localparam int unsigned G_CTX  = 4;
  localparam int unsigned G_LINE = 5;

  typedef struct packed {
    logic [CW-1:0] y;
    logic [CW-1:0] x;
  } coord_t;

  function automatic logic [DW-1:0] pack_coord(coord_t c);
    logic [DW-1:0] w;
    w             = '0;
    w[CW-1:0]     = c.x;
    w[YLSB +: CW] = c.y;
    return w;
  endfunction

endpackage

// File: rtl/disp_tgen_regs.sv
module disp_tgen_regs
  import disp_tgen_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned NLINE = 4,
  parameter int unsigned AW    = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [AW-1:0]                  addr,
  input  logic [DW-1:0]                  wdata,
  output logic [DW-1:0]                  rdata,
  input  logic [NLINE-1:0]               stat,
  input  logic                           frame_end,
  output logic                           run,
  output logic [NCH-1:0]                 ch_en,
  output logic [NLINE-1:0]               mask,
  output logic [NLINE-1:0]               clr,
  output coord_t [5+NLINE+2*NCH-1:0]     geo
);

  localparam int unsigned NGEO = 5 + NLINE + 2*NCH;

  logic                 run_q, run_d;
  logic [NCH-1:0]       en_q, en_d;
  logic [NLINE-1:0]     mask_q, mask_d;
  coord_t [NGEO-1:0]    pend_q, pend_d;
  coord_t [NGEO-1:0]    act_q, act_d;
  logic                 act_load;
  coord_t               wcoord;
  logic                 unused_wdata;

  assign wcoord.x     = wdata[CW-1:0];
  assign wcoord.y     = wdata[YLSB +: CW];
  assign unused_wdata = ^{wdata[DW-1:YLSB+CW], wdata[YLSB-1:CW]};

  // staged geometry reaches the timing logic only between frames
  assign act_load = !run_q || frame_end;

  always_comb begin
    run_d  = run_q;
    en_d   = en_q;
    mask_d = mask_q;
    pend_d = pend_q;
    clr    = '0;
    if (wr_en) begin
      if (addr == AW'(A_CTRL)) begin
        run_d = wdata[START_BIT];
        for (int i = 0; i < NCH; i++) en_d[i] = wdata[NCH-1-i];
      end
      if (addr == AW'(A_MASK)) mask_d = wdata[NLINE-1:0];
      if (addr == AW'(A_CLR))  clr    = wdata[NLINE-1:0];
      for (int g = 0; g < NGEO; g++) begin
        if (addr == AW'(A_GEO + g)) pend_d[g] = wcoord;
      end
    end
    act_d = act_load ? pend_q : act_q;
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(A_CTRL)) begin
      rdata[START_BIT] = run_q;
      for (int i = 0; i < NCH; i++) rdata[NCH-1-i] = en_q[i];
    end
    if (addr == AW'(A_STAT)) rdata[NLINE-1:0] = stat;
    if (addr == AW'(A_MASK)) rdata[NLINE-1:0] = mask_q;
    for (int g = 0; g < NGEO; g++) begin
      if (addr == AW'(A_GEO + g)) rdata = pack_coord(pend_q[g]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      en_q   <= '0;
      mask_q <= '0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      run_q  <= run_d;
      en_q   <= en_d;
      mask_q <= mask_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign run   = run_q;
  assign ch_en = en_q;
  assign mask  = mask_q;
  assign geo   = act_q;

  AST_GEO_FROZEN_MIDFRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !frame_end) |=> $stable(act_q)); // R12

endmodule

// File: rtl/disp_tgen_cnt.sv
module disp_tgen_cnt
  import disp_tgen_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  input  coord_t ext,
  output coord_t pos,
  output logic   frame_end
);

  coord_t pos_q, pos_d;
  logic   x_end, y_end;

  assign x_end     = (pos_q.x == ext.x);
  assign y_end     = (pos_q.y == ext.y);
  assign frame_end = run && x_end && y_end;

  always_comb begin
    pos_d = pos_q;
    if (!run) begin
      pos_d = '0;
    end else if (x_end) begin
      pos_d.x = '0;
      pos_d.y = y_end ? '0 : pos_q.y + 1'b1;
    end else begin
      pos_d.x = pos_q.x + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos_q <= '0;
    else        pos_q <= pos_d;
  end

  assign pos = pos_q;

  AST_X_WITHIN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos_q.x <= ext.x) && (pos_q.y <= ext.y)); // R2
  AST_X_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (run && x_end) |=> (pos_q.x == '0)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pos_q == '0)); // R11

endmodule

// File: rtl/disp_tgen_win.sv
module disp_tgen_win
  import disp_tgen_pkg::*;
(
  input  logic   run,
  input  logic   en,
  input  coord_t pos,
  input  coord_t top,
  input  coord_t bot,
  output logic   act
);

  logic in_x, in_y;

  // top corner exclusive, bottom corner inclusive; all-zero corners give an empty window
  assign in_x = (pos.x > top.x) && (pos.x <= bot.x);
  assign in_y = (pos.y > top.y) && (pos.y <= bot.y);
  assign act  = run && en && in_x && in_y;

endmodule

// File: rtl/disp_tgen_irq.sv
module disp_tgen_irq
  import disp_tgen_pkg::*;
#(
  parameter int unsigned NLINE = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  coord_t               pos,
  input  coord_t               ctx,
  input  coord_t [NLINE-1:0]   lines,
  input  logic   [NLINE-1:0]   clr,
  input  logic   [NLINE-1:0]   mask,
  output logic   [NLINE-1:0]   stat,
  output logic                 irq,
  output logic                 db_pulse,
  output logic                 sb_pulse
);

  logic             sol;
  logic [NLINE-1:0] ev;
  logic [NLINE-1:0] stat_q, stat_d;
  logic [NLINE-1:0] unused_lx;

  assign sol      = run && (pos.x == '0);
  assign db_pulse = sol && (pos.y == ctx.x);
  assign sb_pulse = sol && (pos.y == ctx.y);

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    assign ev[k]        = sol && (pos.y == lines[k].y);
    assign unused_lx[k] = ^lines[k].x;

    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q[k] && !clr[k]) |=> stat_q[k]); // R7
    AST_STAT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !ev[k]) |=> !stat_q[k]); // R8
  end

  // an event in the same cycle as its clear survives
  assign stat_d = (stat_q & ~clr) | ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = |(stat_q & mask);

endmodule

// File: rtl/disp_tgen_top.sv
module disp_tgen_top
  import disp_tgen_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned NLINE = 4,
  parameter int unsigned AW    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              disp_en,
  output logic [NCH-1:0]    ch_act,
  output logic [12:0]       pos_x,
  output logic [12:0]       pos_y,
  output logic              ctx_db_pulse,
  output logic              ctx_sb_pulse,
  output logic              irq
);

  localparam int unsigned NGEO   = 5 + NLINE + 2*NCH;
  localparam int unsigned G_CHAN = G_LINE + NLINE;

  logic              rst_meta, rst_int;
  logic              run, frame_end;
  logic [NCH-1:0]    ch_en;
  logic [NLINE-1:0]  mask, clr, stat;
  coord_t [NGEO-1:0] geo;
  coord_t            pos;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_int  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_int  <= rst_meta;
    end
  end

  disp_tgen_regs #(.NCH(NCH), .NLINE(NLINE), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_int),
    .wr_en     (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .stat      (stat),
    .frame_end (frame_end),
    .run       (run),
    .ch_en     (ch_en),
    .mask      (mask),
    .clr       (clr),
    .geo       (geo)
  );

  disp_tgen_cnt cnt_i (
    .clk       (clk),
    .rst_n     (rst_int),
    .run       (run),
    .ext       (geo[G_EXT]),
    .pos       (pos),
    .frame_end (frame_end)
  );

  disp_tgen_win disp_win_i (
    .run (run),
    .en  (1'b1),
    .pos (pos),
    .top (geo[G_DTOP]),
    .bot (geo[G_DBOT]),
    .act (disp_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    disp_tgen_win ch_win_i (
      .run (run),
      .en  (ch_en[c]),
      .pos (pos),
      .top (geo[G_CHAN + 2*c]),
      .bot (geo[G_CHAN + 2*c + 1]),
      .act (ch_act[c])
    );
  end

  disp_tgen_irq #(.NLINE(NLINE)) irq_i (
    .clk      (clk),
    .rst_n    (rst_int),
    .run      (run),
    .pos      (pos),
    .ctx      (geo[G_CTX]),
    .lines    (geo[G_LINE +: NLINE]),
    .clr      (clr),
    .mask     (mask),
    .stat     (stat),
    .irq      (irq),
    .db_pulse (ctx_db_pulse),
    .sb_pulse (ctx_sb_pulse)
  );

  assign hsync = run && (pos.x < geo[G_SYNC].x);
  assign vsync = run && (pos.y < geo[G_SYNC].y);
  assign pos_x = pos.x;
  assign pos_y = pos.y;

  AST_IDLE_OUTPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_int)
    !run |-> !hsync && !vsync && !disp_en && (ch_act == '0)
             && !ctx_db_pulse && !ctx_sb_pulse); // R11

endmodule

// File: tb/disp_tgen_tb.sv
module disp_tgen_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, disp_en, ctx_db_pulse, ctx_sb_pulse, irq;
  logic [2:0]  ch_act;
  logic [12:0] pos_x, pos_y;

  always #4 clk = ~clk;  // 125 MHz

  disp_tgen_top dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .hsync        (hsync),
    .vsync        (vsync),
    .disp_en      (disp_en),
    .ch_act       (ch_act),
    .pos_x        (pos_x),
    .pos_y        (pos_y),
    .ctx_db_pulse (ctx_db_pulse),
    .ctx_sb_pulse (ctx_sb_pulse),
    .irq          (irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model; geometry index i lives at offset 4+i
  int       px[15], py[15];  // staged
  int       cx[15], cy[15];  // in use
  int       mx = 0, my = 0;
  bit       mrun = 1'b0;
  bit [2:0] men = '0;        // men[c] enables channel c+1
  bit [3:0] mstat = '0, mmask = '0;
  string    pos_tag = "R2";

  task automatic chk(input string req, input string nm, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
    end
  endtask

  function automatic bit inw(int x, int y, int t, int b);
    return (x > cx[t]) && (x <= cx[b]) && (y > cy[t]) && (y <= cy[b]);
  endfunction

  function automatic logic [31:0] pk(int x, int y);
    logic [31:0] w;
    w = '0;
    w[12:0]  = x[12:0];
    w[28:16] = y[12:0];
    return w;
  endfunction

  function automatic logic [31:0] mrd(int a);
    logic [31:0] w;
    w = '0;
    if (a == 0) begin w[8] = mrun; w[2] = men[0]; w[1] = men[1]; w[0] = men[2]; end
    else if (a == 1) w[3:0] = mstat;
    else if (a == 3) w[3:0] = mmask;
    else if (a >= 4 && a <= 18) w = pk(px[a-4], py[a-4]);
    return w;
  endfunction

  // one cycle: drive at negedge, check, model the following edge
  task automatic cyc(input bit wr, input int addr, input logic [31:0] data);
    bit [3:0] ev, clr;
    bit       z, e;
    reg_wr    = wr;
    reg_addr  = addr[4:0];
    reg_wdata = data;
    #1;
    chk(pos_tag, "pos_x", 32'(pos_x), 32'(mx));
    chk(pos_tag, "pos_y", 32'(pos_y), 32'(my));
    chk(mrun ? "R6" : "R11", "hsync", 32'(hsync), 32'(mrun && mx < cx[3]));
    chk(mrun ? "R6" : "R11", "vsync", 32'(vsync), 32'(mrun && my < cy[3]));
    chk(mrun ? "R3" : "R11", "disp_en", 32'(disp_en), 32'(mrun && inw(mx, my, 1, 2)));
    for (int c = 0; c < 3; c++) begin
      z = (cx[9+2*c] == 0) && (cy[9+2*c] == 0) && (cx[10+2*c] == 0) && (cy[10+2*c] == 0);
      e = mrun && men[c] && inw(mx, my, 9+2*c, 10+2*c);
      chk(z ? "R5" : (mrun ? "R4" : "R11"), $sformatf("ch_act[%0d]", c), 32'(ch_act[c]), 32'(e));
    end
    chk("R10", "ctx_db_pulse", 32'(ctx_db_pulse), 32'(mrun && mx == 0 && my == cx[4]));
    chk("R10", "ctx_sb_pulse", 32'(ctx_sb_pulse), 32'(mrun && mx == 0 && my == cy[4]));
    chk("R9", "irq", 32'(irq), 32'(|(mstat & mmask)));
    chk(addr == 1 ? "R7" : (addr >= 4 ? "R1" : "R4"), $sformatf("rdata@%0d", addr), reg_rdata, mrd(addr));
    @(posedge clk);
    for (int k = 0; k < 4; k++) ev[k] = mrun && mx == 0 && my == cy[5+k];
    clr   = (wr && addr == 2) ? data[3:0] : 4'h0;
    mstat = (mstat & ~clr) | ev;
    if (!mrun) begin
      mx = 0; my = 0;
      for (int i = 0; i < 15; i++) begin cx[i] = px[i]; cy[i] = py[i]; end
    end else if (mx == cx[0] && my == cy[0]) begin
      mx = 0; my = 0;
      for (int i = 0; i < 15; i++) begin cx[i] = px[i]; cy[i] = py[i]; end
    end else if (mx == cx[0]) begin
      mx = 0; my = my + 1;
    end else begin
      mx = mx + 1;
    end
    if (wr) begin
      if (addr == 0) begin mrun = data[8]; men[0] = data[2]; men[1] = data[1]; men[2] = data[0]; end
      if (addr == 3) mmask = data[3:0];
      if (addr >= 4 && addr <= 18) begin px[addr-4] = int'(data[12:0]); py[addr-4] = int'(data[28:16]); end
    end
    @(negedge clk);
  endtask

  task automatic wr_geo(input int idx, input int x, input int y);
    cyc(1'b1, idx + 4, pk(x, y) | ($urandom & 32'hE000_E000));
  endtask

  task automatic run_cycles(input int n, input int inj_at, input int inj_addr, input logic [31:0] inj_data);
    for (int i = 0; i < n; i++) begin
      if (i == inj_at) cyc(1'b1, inj_addr, inj_data);
      else             cyc(1'b0, int'($urandom % 19), 32'h0);
    end
  endtask

  task automatic program_random();
    int lx, ly, tx, ty;
    lx = 8 + int'($urandom % 16);
    ly = 5 + int'($urandom % 8);
    cyc(1'b1, 0, 32'h0);
    wr_geo(0, lx, ly);
    wr_geo(1, int'($urandom % 4), int'($urandom % 3));
    wr_geo(2, lx - int'($urandom % 4), ly - int'($urandom % 2));
    wr_geo(3, 1 + int'($urandom % 3), 1 + int'($urandom % 2));
    wr_geo(4, int'($urandom % (ly + 1)), int'($urandom % (ly + 1)));
    for (int k = 0; k < 4; k++) wr_geo(5 + k, int'($urandom % 64), int'($urandom % (ly + 1)));
    for (int c = 0; c < 3; c++) begin
      if ($urandom % 4 == 0) begin
        wr_geo(9 + 2*c, 0, 0);
        wr_geo(10 + 2*c, 0, 0);
      end else begin
        tx = int'($urandom % lx);
        ty = int'($urandom % ly);
        wr_geo(9 + 2*c, tx, ty);
        wr_geo(10 + 2*c, tx + 1 + int'($urandom % 6), ty + 1 + int'($urandom % 4));
      end
    end
    cyc(1'b1, 3, 32'($urandom % 16));
    cyc(1'b1, 2, 32'hF);
    cyc(1'b1, 0, 32'h100 | 32'($urandom % 8));
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int fl, inj, a;
    void'($urandom(32'd1729));
    for (int i = 0; i < 15; i++) begin px[i] = 0; py[i] = 0; cx[i] = 0; cy[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state, R11
    for (int a0 = 0; a0 < 19; a0++) cyc(1'b0, a0, 32'h0);

    // stopped with geometry loaded: everything quiet, R11
    wr_geo(0, 9, 6);
    wr_geo(1, 2, 1);
    wr_geo(2, 8, 5);
    wr_geo(3, 2, 1);
    wr_geo(4, 6, 0);   // db trigger line 6, sb trigger line 0
    wr_geo(5, 0, 0);
    wr_geo(6, 5, 3);
    wr_geo(7, 0, 6);
    wr_geo(8, 0, 2);
    wr_geo(9, 3, 2);   // channel 1
    wr_geo(10, 5, 4);
    wr_geo(11, 0, 0);  // channel 2 empty, R5
    wr_geo(12, 0, 0);
    wr_geo(13, 0, 0);  // channel 3 covers all but first row/column
    wr_geo(14, 9, 6);
    cyc(1'b1, 3, 32'h5);
    cyc(1'b1, 0, 32'h007);  // enables set, start clear
    run_cycles(12, -1, 0, 32'h0);

    // directed run, clear mid-frame (R8), then frame size change mid-frame (R12)
    cyc(1'b1, 0, 32'h107);
    run_cycles(200, 97, 2, 32'hF);
    pos_tag = "R12";
    run_cycles(250, 33, 4, pk(11, 7));
    pos_tag = "R2";
    run_cycles(40, 5, 2, 32'h3);

    // stop mid-frame, R11
    cyc(1'b1, 0, 32'h000);
    run_cycles(10, -1, 0, 32'h0);

    // random rounds
    for (int r = 0; r < 14; r++) begin
      program_random();
      fl  = (cx[0] + 1) * (cy[0] + 1);
      inj = int'($urandom % fl);
      case ($urandom % 4)
        0: a = 2;
        1: a = 3;
        2: a = 0;
        default: a = 4;
      endcase
      if (a == 4)      run_cycles(2*fl + 30, inj, 4, pk(8 + int'($urandom % 16), 5 + int'($urandom % 8)));
      else if (a == 0) run_cycles(2*fl + 30, inj, 0, 32'h100 | 32'($urandom % 8));
      else             run_cycles(2*fl + 30, inj, a, 32'($urandom % 16));
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule